// File: doc/BRIEF.md
# Writable Instruction Dispatch Decoder

This block sits between instruction fetch and a microsequencer. Each fetched instruction word indexes a writable table directly. The table has one entry for every possible word value. An entry lists up to three microcode start addresses and a small count of how many of them apply. The block presents those addresses to the sequencer one at a time and moves to the next address only after the sequencer reports that the current routine has run to completion. A typical use is a two-operand memory-to-memory instruction, which dispatches a fetch routine for each operand and then an execute routine. A register-to-register instruction needs only the execute routine.

The table is plain RAM with no reset. A boot agent fills it through a simple write port and then pulses a finish strobe. Until that strobe has been seen, the decoder refuses instructions. Because the table can be rewritten, the instruction mapping can change without a change to the hardware. The index width, the microcode address width, the number of address slots and the count width are all parameters. With the default values each entry is 32 bits wide. A 16-bit index gives the full 65,536-entry table; the default index width is smaller.

Top module: `ucode_dispatch`

## Requirements
- R1: A cycle with `ld_we` high writes `ld_data` into the entry at `ld_addr`. Each later dispatch of that index uses the new contents. The entry layout is: count in bits [31:30], slot 2 in [29:20], slot 1 in [19:10], slot 0 in [9:0].
- R2: After reset, `instr_ready` stays low and `instr_valid` is ignored until `ld_finish` has been sampled high. From the following cycle onward, `instr_ready` is high whenever the block is idle.
- R3: An instruction is accepted in a cycle where `instr_valid` and `instr_ready` are both high, and its word is registered. `uaddr_valid` first rises in the third cycle after the accepting cycle. `instr_ready` stays low until the sequence ends.
- R4: An entry with count n (1 to 3) presents slots n-1 down to 0, in that order, and never more than n addresses.
- R5: While `uaddr_valid` is high and `uaddr_ready` is low, `uaddr_valid` stays high and `uaddr` holds its value.
- R6: After a handshake (`uaddr_valid` and `uaddr_ready` both high), `uaddr_valid` stays low until `routine_done` is sampled high. The next address is then presented in the following cycle.
- R7: `instr_done` is high for exactly the cycle in which `routine_done` ends the last routine. `instr_ready` is high in the next cycle.
- R8: An entry with count 0 raises `illegal_instr` for one cycle (the second cycle after acceptance). It presents no address, does not raise `instr_done`, and the block is ready again in the next cycle.
- R9: A register-to-register entry (count 1) presents only slot 0, even when slots 1 and 2 hold nonzero data.
- R10: Writing the table entry of an instruction while that instruction is being dispatched does not change the addresses of the dispatch in progress.
- R11: During and right after reset, `instr_ready`, `uaddr_valid`, `instr_done` and `illegal_instr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Table write enable |
| ld_addr | input | INSTR_W | Table write index |
| ld_data | input | CNT_W+NUM_SLOTS*UADDR_W | Table write data (count and slots) |
| ld_finish | input | 1 | Strobe marking that the table is loaded |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | INSTR_W | Instruction word |
| instr_ready | output | 1 | Decoder is idle and armed |
| uaddr_valid | output | 1 | Microcode entry address is presented |
| uaddr_ready | input | 1 | Sequencer takes the presented address |
| uaddr | output | UADDR_W | Microcode entry address |
| routine_done | input | 1 | Sequencer finished the current routine |
| instr_done | output | 1 | Last routine of the instruction finished |
| illegal_instr | output | 1 | Entry count was zero (or above NUM_SLOTS) |

## Verification
Some properties can be judged every cycle from the ports alone, and the assertions check these throughout. The decoder stays closed before arming. A presented address is held under backpressure. Nothing is presented between a handshake and `routine_done`. No more than three handshakes occur per instruction. Completion and illegal pulses are clean and reopen the input. The bench scenarios are needed for everything that depends on table contents. This covers the order of the slots for each count, the masking of unused slots for a one-address entry, the exact first-issue latency, and a rewrite in the middle of a dispatch leaving the running sequence untouched while the next dispatch sees the new entry.

// File: rtl/udisp_pkg.sv
package udisp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_DECODE,
      ST_ISSUE,
      ST_WAIT
   } disp_state_e;

   function automatic int unsigned slot_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/udisp_arm.sv
module udisp_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_finish,
   output logic armed
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         armed <= 1'b0;
      else if (ld_finish) armed <= 1'b1;
   end

endmodule

// File: rtl/udisp_table.sv
module udisp_table #(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned ENTRY_W = 32
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic               rd_en,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ENTRY_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [ENTRY_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   // read port only captures on request, so the entry is frozen for the sequence
   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_idx];
   end

endmodule

// File: rtl/udisp_field_sel.sv
module udisp_field_sel #(
   parameter int unsigned UADDR_W   = 10,
   parameter int unsigned NUM_SLOTS = 3,
   parameter int unsigned SLOT_W    = 2
) (
   input  logic [NUM_SLOTS*UADDR_W-1:0] fields,
   input  logic [SLOT_W-1:0]            slot,
   output logic [UADDR_W-1:0]           uaddr
);

   logic [UADDR_W-1:0] slot_val [NUM_SLOTS];

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slice
      assign slot_val[g] = fields[g*UADDR_W +: UADDR_W];
   end

   always_comb begin
      uaddr = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (slot == SLOT_W'(i)) uaddr = slot_val[i];
      end
   end

endmodule

// File: rtl/udisp_seq.sv
module udisp_seq
   import udisp_pkg::*;
#(
   parameter int unsigned IDX_W     = 8,
   parameter int unsigned CNT_W     = 2,
   parameter int unsigned NUM_SLOTS = 3,
   parameter int unsigned SLOT_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic              instr_valid,
   input  logic [IDX_W-1:0]  instr_word,
   output logic              instr_ready,
   output logic [IDX_W-1:0]  idx_q,
   output logic              rd_en,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              uaddr_ready,
   input  logic              routine_done,
   output logic              uaddr_valid,
   output logic [SLOT_W-1:0] slot_q,
   output logic              instr_done,
   output logic              illegal
);

   disp_state_e state_q, state_d;
   logic        accept;
   logic        cnt_bad;
   logic        last_slot;

   assign instr_ready = armed && (state_q == ST_IDLE);
   assign accept      = instr_ready && instr_valid;
   assign rd_en       = (state_q == ST_FETCH);
   assign cnt_bad     = (cnt == '0) || (int'(cnt) > NUM_SLOTS);
   assign last_slot   = (slot_q == '0);
   assign uaddr_valid = (state_q == ST_ISSUE);
   assign illegal     = (state_q == ST_DECODE) && cnt_bad;
   assign instr_done  = (state_q == ST_WAIT) && routine_done && last_slot;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (accept) state_d = ST_FETCH;
         ST_FETCH:  state_d = ST_DECODE;
         ST_DECODE: state_d = cnt_bad ? ST_IDLE : ST_ISSUE;
         ST_ISSUE:  if (uaddr_ready) state_d = ST_WAIT;
         ST_WAIT:   if (routine_done) state_d = last_slot ? ST_IDLE : ST_ISSUE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         slot_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) idx_q <= instr_word;
         if (state_q == ST_DECODE && !cnt_bad)
            slot_q <= SLOT_W'(cnt) - SLOT_W'(1);
         else if (state_q == ST_WAIT && routine_done && !last_slot)
            slot_q <= slot_q - SLOT_W'(1);
      end
   end

endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
   import udisp_pkg::*;
#(
   parameter int unsigned INSTR_W   = 8,
   parameter int unsigned UADDR_W   = 10,
   parameter int unsigned NUM_SLOTS = 3,
   parameter int unsigned CNT_W     = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              ld_we,
   input  logic [INSTR_W-1:0]                ld_addr,
   input  logic [CNT_W+NUM_SLOTS*UADDR_W-1:0] ld_data,
   input  logic                              ld_finish,
   input  logic                              instr_valid,
   input  logic [INSTR_W-1:0]                instr_word,
   output logic                              instr_ready,
   output logic                              uaddr_valid,
   input  logic                              uaddr_ready,
   output logic [UADDR_W-1:0]                uaddr,
   input  logic                              routine_done,
   output logic                              instr_done,
   output logic                              illegal_instr
);

   localparam int unsigned FIELDS_W = NUM_SLOTS * UADDR_W;
   localparam int unsigned ENTRY_W  = CNT_W + FIELDS_W;
   localparam int unsigned SLOT_W   = slot_bits(NUM_SLOTS);

   if (INSTR_W < 1 || INSTR_W > 16) begin : g_chk_idx
      $error("INSTR_W must lie in 1..16");
   end
   if (NUM_SLOTS < 1) begin : g_chk_slots
      $error("NUM_SLOTS must be at least 1");
   end
   if ((1 << CNT_W) <= NUM_SLOTS) begin : g_chk_cnt
      $error("CNT_W too narrow to count NUM_SLOTS");
   end

   logic                 armed;
   logic [INSTR_W-1:0]   idx_q;
   logic                 rd_en;
   logic [ENTRY_W-1:0]   entry;
   logic [SLOT_W-1:0]    slot_q;

   udisp_arm u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_finish (ld_finish),
      .armed     (armed)
   );

   udisp_table #(
      .IDX_W   (INSTR_W),
      .ENTRY_W (ENTRY_W)
   ) u_table (
      .clk     (clk),
      .wr_en   (ld_we),
      .wr_idx  (ld_addr),
      .wr_data (ld_data),
      .rd_en   (rd_en),
      .rd_idx  (idx_q),
      .rd_data (entry)
   );

   udisp_seq #(
      .IDX_W     (INSTR_W),
      .CNT_W     (CNT_W),
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .armed        (armed),
      .instr_valid  (instr_valid),
      .instr_word   (instr_word),
      .instr_ready  (instr_ready),
      .idx_q        (idx_q),
      .rd_en        (rd_en),
      .cnt          (entry[ENTRY_W-1 -: CNT_W]),
      .uaddr_ready  (uaddr_ready),
      .routine_done (routine_done),
      .uaddr_valid  (uaddr_valid),
      .slot_q       (slot_q),
      .instr_done   (instr_done),
      .illegal      (illegal_instr)
   );

   udisp_field_sel #(
      .UADDR_W   (UADDR_W),
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W)
   ) u_sel (
      .fields (entry[FIELDS_W-1:0]),
      .slot   (slot_q),
      .uaddr  (uaddr)
   );

endmodule

// File: rtl/udisp_checker.sv
module udisp_checker #(
   parameter int unsigned UADDR_W   = 10,
   parameter int unsigned NUM_SLOTS = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ld_finish,
   input logic               instr_valid,
   input logic               instr_ready,
   input logic               uaddr_valid,
   input logic               uaddr_ready,
   input logic [UADDR_W-1:0] uaddr,
   input logic               routine_done,
   input logic               instr_done,
   input logic               illegal_instr
);

   localparam int unsigned HW = $clog2(NUM_SLOTS + 2);

   logic          armed_q;
   logic          wait_q;
   logic [HW-1:0] hs_cnt;
   logic          hs;

   assign hs = uaddr_valid && uaddr_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         wait_q  <= 1'b0;
         hs_cnt  <= '0;
      end else begin
         if (ld_finish) armed_q <= 1'b1;
         if (hs) wait_q <= 1'b1;
         else if (routine_done) wait_q <= 1'b0;
         if (instr_valid && instr_ready) hs_cnt <= '0;
         else if (hs) hs_cnt <= hs_cnt + HW'(1);
      end
   end

   a_r2_closed_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> !instr_ready);

   a_r3_idle_not_issuing: assert property (@(posedge clk) disable iff (!rst_n)
      instr_ready |-> !uaddr_valid);

   a_r4_slot_limit: assert property (@(posedge clk) disable iff (!rst_n)
      hs_cnt <= HW'(NUM_SLOTS));

   a_r5_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (uaddr_valid && !uaddr_ready) |=> (uaddr_valid && $stable(uaddr)));

   a_r6_quiet_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q |-> !uaddr_valid);

   a_r7_done_with_routine: assert property (@(posedge clk) disable iff (!rst_n)
      instr_done |-> routine_done);

   a_r7_done_reopens: assert property (@(posedge clk) disable iff (!rst_n)
      instr_done |=> instr_ready);

   a_r8_illegal_clean: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_instr |-> (!uaddr_valid && !instr_done));

   a_r8_illegal_reopens: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_instr |=> (instr_ready && !illegal_instr));

endmodule

bind ucode_dispatch udisp_checker #(
   .UADDR_W   (UADDR_W),
   .NUM_SLOTS (NUM_SLOTS)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .ld_finish     (ld_finish),
   .instr_valid   (instr_valid),
   .instr_ready   (instr_ready),
   .uaddr_valid   (uaddr_valid),
   .uaddr_ready   (uaddr_ready),
   .uaddr         (uaddr),
   .routine_done  (routine_done),
   .instr_done    (instr_done),
   .illegal_instr (illegal_instr)
);

// File: tb/ucode_dispatch_tb_top.sv
`timescale 1ns/1ps
module ucode_dispatch_tb_top;

   localparam int IW = 8;
   localparam int AW = 10;
   localparam int EW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_we = 1'b0;
   logic [IW-1:0] ld_addr = '0;
   logic [EW-1:0] ld_data = '0;
   logic          ld_finish = 1'b0;
   logic          instr_valid = 1'b0;
   logic [IW-1:0] instr_word = '0;
   logic          instr_ready;
   logic          uaddr_valid;
   logic          uaddr_ready = 1'b0;
   logic [AW-1:0] uaddr;
   logic          routine_done = 1'b0;
   logic          instr_done;
   logic          illegal_instr;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   ucode_dispatch dut_i (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
      .ld_finish(ld_finish), .instr_valid(instr_valid), .instr_word(instr_word),
      .instr_ready(instr_ready), .uaddr_valid(uaddr_valid), .uaddr_ready(uaddr_ready),
      .uaddr(uaddr), .routine_done(routine_done), .instr_done(instr_done),
      .illegal_instr(illegal_instr)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000) begin
         fails = fails + 1;
         $display("FAIL watchdog: act=%0d cycles exp=completion", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   function automatic logic [EW-1:0] mk(input int c, input int s2, input int s1, input int s0);
      return {2'(c), 10'(s2), 10'(s1), 10'(s0)};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic tbl_write(input int idx, input logic [EW-1:0] d);
      @(negedge clk);
      ld_we = 1'b1; ld_addr = IW'(idx); ld_data = d;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic send(input int w);
      @(negedge clk);
      instr_valid = 1'b1; instr_word = IW'(w);
      while (!instr_ready) @(negedge clk);
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   // runs one instruction as a sequencer; slots listed as s2,s1,s0
   task automatic run_instr(input int w, input int n, input int s2, input int s1, input int s0,
                            input int stall, input bit rewrite, input logic [EW-1:0] newval,
                            input string req);
      int exp_a [3];
      exp_a[0] = s0; exp_a[1] = s1; exp_a[2] = s2;
      send(w);
      chk(uaddr_valid == 1'b0, "R3", "valid 1st cycle after accept", int'(uaddr_valid), 0);
      chk(instr_ready == 1'b0, "R3", "ready while busy", int'(instr_ready), 0);
      @(negedge clk);
      chk(illegal_instr == (n == 0), "R8", "illegal pulse", int'(illegal_instr), int'(n == 0));
      chk(uaddr_valid == 1'b0, "R3", "valid 2nd cycle after accept", int'(uaddr_valid), 0);
      @(negedge clk);
      if (n == 0) begin
         chk(illegal_instr == 1'b0, "R8", "illegal one cycle", int'(illegal_instr), 0);
         chk(uaddr_valid == 1'b0, "R8", "no dispatch", int'(uaddr_valid), 0);
         chk(instr_done == 1'b0, "R8", "no done", int'(instr_done), 0);
         chk(instr_ready == 1'b1, "R8", "ready again", int'(instr_ready), 1);
         return;
      end
      for (int k = n - 1; k >= 0; k--) begin
         chk(uaddr_valid == 1'b1, "R3", "address presented", int'(uaddr_valid), 1);
         chk(int'(uaddr) == exp_a[k], req, "slot address", int'(uaddr), exp_a[k]);
         if (rewrite && k == n - 1) begin
            ld_we = 1'b1; ld_addr = IW'(w); ld_data = newval;
            @(negedge clk);
            ld_we = 1'b0;
            chk(int'(uaddr) == exp_a[k], "R10", "addr after rewrite", int'(uaddr), exp_a[k]);
         end
         for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(uaddr_valid && int'(uaddr) == exp_a[k], "R5", "hold under stall",
                int'(uaddr), exp_a[k]);
         end
         uaddr_ready = 1'b1;
         @(negedge clk);
         uaddr_ready = 1'b0;
         for (int g = 0; g < 2; g++) begin
            chk(uaddr_valid == 1'b0, "R6", "quiet before routine_done", int'(uaddr_valid), 0);
            chk(instr_done == 1'b0, "R7", "early done", int'(instr_done), 0);
            @(negedge clk);
         end
         routine_done = 1'b1;
         #1;
         chk(instr_done == (k == 0), "R7", "done with last routine", int'(instr_done), int'(k == 0));
         @(negedge clk);
         routine_done = 1'b0;
      end
      chk(instr_ready == 1'b1, "R7", "ready after done", int'(instr_ready), 1);
      chk(uaddr_valid == 1'b0, "R4", "no extra address", int'(uaddr_valid), 0);
      chk(instr_done == 1'b0, "R7", "done one cycle", int'(instr_done), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!instr_ready && !uaddr_valid && !instr_done && !illegal_instr, "R11",
          "outputs in reset", int'({instr_ready, uaddr_valid, instr_done, illegal_instr}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!instr_ready && !uaddr_valid && !instr_done && !illegal_instr, "R11",
          "outputs after reset", int'({instr_ready, uaddr_valid, instr_done, illegal_instr}), 0);
   endtask

   task automatic t_unarmed();
      instr_valid = 1'b1; instr_word = 8'h21;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(instr_ready == 1'b0, "R2", "ready before load done", int'(instr_ready), 0);
         chk(uaddr_valid == 1'b0, "R2", "dispatch before load done", int'(uaddr_valid), 0);
      end
      instr_valid = 1'b0;
   endtask

   task automatic t_load();
      @(negedge clk);
      ld_we = 1'b1;
      for (int i = 0; i < 256; i++) begin
         ld_addr = IW'(i); ld_data = '0;
         @(negedge clk);
      end
      ld_we = 1'b0;
      tbl_write(8'h21, mk(3, 'h101, 'h202, 'h303));
      tbl_write(8'h05, mk(1, 'h3FF, 'h155, 'h0AA));
      tbl_write(8'h80, mk(2, 'h2AA, 'h111, 'h222));
      tbl_write(8'h44, mk(0, 'h123, 'h234, 'h345));
      tbl_write(8'h30, mk(2, 'h000, 'h050, 'h060));
      tbl_write(8'hFF, mk(3, 'h3FF, 'h000, 'h3FE));
      tbl_write(8'h00, mk(1, 'h000, 'h000, 'h001));
      chk(instr_ready == 1'b0, "R2", "ready during load", int'(instr_ready), 0);
      ld_finish = 1'b1;
      #1;
      chk(instr_ready == 1'b0, "R2", "ready in finish cycle", int'(instr_ready), 0);
      @(negedge clk);
      ld_finish = 1'b0;
      chk(instr_ready == 1'b1, "R2", "ready after finish", int'(instr_ready), 1);
      repeat (3) @(negedge clk);
      chk(uaddr_valid == 1'b0, "R2", "earlier offer ignored", int'(uaddr_valid), 0);
   endtask

   initial begin
      t_reset();
      t_unarmed();
      t_load();
      run_instr(8'h21, 3, 'h101, 'h202, 'h303, 0, 1'b0, '0, "R4");
      run_instr(8'h05, 1, 'h3FF, 'h155, 'h0AA, 0, 1'b0, '0, "R9");
      run_instr(8'h80, 2, 'h2AA, 'h111, 'h222, 0, 1'b0, '0, "R4");
      run_instr(8'h44, 0, 0, 0, 0, 0, 1'b0, '0, "R8");
      run_instr(8'h21, 3, 'h101, 'h202, 'h303, 3, 1'b0, '0, "R5");
      run_instr(8'h30, 2, 'h000, 'h050, 'h060, 0, 1'b1, mk(2, 'h000, 'h070, 'h080), "R10");
      run_instr(8'h30, 2, 'h000, 'h070, 'h080, 0, 1'b0, '0, "R1");
      run_instr(8'hFF, 3, 'h3FF, 'h000, 'h3FE, 1, 1'b0, '0, "R4");
      run_instr(8'h00, 1, 'h000, 'h000, 'h001, 0, 1'b0, '0, "R9");
      repeat (2) @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule